// File: doc/BRIEF.md
# Dual-Line Serial OTP Read Target

This block is the target side of a serial memory link that runs in a two-line mode. Every instruction bit, address bit and returned data bit moves two per clock, on data lines DQ1 and DQ0. The block recognises three frames:

- A read of a 64-byte one-time-programmable area.
- A frame that sets a write-enable latch.
- A frame that clears that latch.

The host holds chip select low for the whole frame. It toggles the serial clock and drives or samples the two lines. Each line is modelled as a separate input, output and output-enable.

A read frame has four parts in order:

1. The opcode, over 4 clocks.
2. A 24-bit address, over 12 clocks.
3. Eight dummy clocks, which leave time for the internal access and are not shortened by the two-line mode.
4. A byte stream. Each byte takes 4 clocks, and the stream continues until chip select rises.

The OTP contents are loaded through a preload port while chip select is high. The state of the latch is driven on a dedicated output.

Top module: `dio_otp_responder`

## Requirements
- R1: Input bits are sampled on the rising edge of `sck` while `cs_n` is low, two per clock, with the higher (odd) bit of each pair on `dq_in[1]` and the lower (even) bit on `dq_in[0]`, most significant pair first. The 8-bit opcode occupies the first 4 clocks; a pair-swapped code such as 0x87 is not taken as the read code 0x4B.
- R2: After opcode 0x4B, the next 12 clocks carry a 24-bit address, most significant pair first. Only the low 6 bits select the starting OTP offset; the upper 18 bits are ignored.
- R3: Exactly 8 dummy clocks follow the address. `dq_oe` stays 2'b00 from the start of the frame until the falling edge that follows the 8th dummy rising edge.
- R4: Each OTP byte is returned over 4 clocks, launched on falling edges. Bits 7:6 come first, then 5:4, 3:2 and 1:0, with the odd bit on `dq_out[1]`. `dq_oe` is 2'b11 for every data clock.
- R5: Bytes stream from consecutive offsets for as long as `cs_n` stays low, and offset 63 is followed by offset 0.
- R6: The 4-clock frame 0x06 sets `wel` to 1 when `cs_n` rises right after the 4th clock.
- R7: The 4-clock frame 0x04 clears `wel` to 0 when `cs_n` rises right after the 4th clock.
- R8: `wel` is left unchanged by three kinds of frame: a 0x06 or 0x04 frame cut short before its 4th clock, one that runs one or more clocks past it, and a read frame.
- R9: A frame whose opcode is not 0x4B, 0x06 or 0x04 drives nothing (`dq_oe` = 2'b00 until `cs_n` rises) and leaves `wel` unchanged.
- R10: `cs_n` high releases both lines immediately and returns the decoder to the opcode phase, so a frame aborted at any point is followed by a correctly decoded frame. Reset (`rst_n` low) clears `wel` and releases the lines.
- R11: While `cs_n` is high, a rising `sck` edge with `pre_we` high writes `pre_data` to OTP offset `pre_addr`. Reads return the most recently written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial clock; inputs sampled on rising edge, data launched on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| dq_in | input | 2 | Sampled data lines, [1] odd bit, [0] even bit |
| dq_out | output | 2 | Driven data lines, [1] odd bit, [0] even bit |
| dq_oe | output | 2 | Output enable per line |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 6 | Preload OTP offset |
| pre_data | input | 8 | Preload byte |
| wel | output | 1 | Write-enable latch state |

## Verification
A miscount of the opcode or address clocks moves the start of the data phase. That shows up as `dq_oe` rising one or more clocks early or late relative to the 8th dummy clock, and the very first returned byte then comes out shifted by a pair. A wrong offset pointer or a missing wrap gives a wrong byte within 4 clocks of the fault. A pending latch operation that is committed or dropped wrongly is visible on `wel` one rising edge after `cs_n` rises.

// File: rtl/dio_otp_pkg.sv
`timescale 1ns/1ps
package dio_otp_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_HOLD,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    WOP_NONE,
    WOP_SET,
    WOP_CLR
  } wop_t;

  localparam logic [7:0] OP_OTP_RD = 8'h4B;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_WR_DIS = 8'h04;

  // shift a new pair (odd bit, even bit) in at the low end
  function automatic logic [7:0] push_pair(input logic [7:0] sr, input logic [1:0] p);
    return {sr[5:0], p};
  endfunction

  // pair number idx of a byte, idx 0 being bits 7:6
  function automatic logic [1:0] byte_pair(input logic [7:0] b, input logic [1:0] idx);
    logic [1:0] r;
    case (idx)
      2'd0:    r = b[7:6];
      2'd1:    r = b[5:4];
      2'd2:    r = b[3:2];
      default: r = b[1:0];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dio_frame_ctl.sv
`timescale 1ns/1ps
module dio_frame_ctl
  import dio_otp_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_CLKS = 8,
  parameter int OFS_W      = 6
) (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [1:0]       dq_in,
  output phase_t           phase,
  output wop_t             wop,
  output logic [OFS_W-1:0] start_ofs,
  output logic             ev_data_start
);
  localparam int CMD_CLKS  = 4;
  localparam int ADDR_CLKS = ADDR_BITS / 2;
  localparam int MAX_CLKS  = (ADDR_CLKS > DUMMY_CLKS) ? ADDR_CLKS : DUMMY_CLKS;
  localparam int CW        = $clog2(MAX_CLKS + 1);
  localparam logic [CW-1:0] CMD_LAST   = CW'(CMD_CLKS - 1);
  localparam logic [CW-1:0] ADDR_LAST  = CW'(ADDR_CLKS - 1);
  localparam logic [CW-1:0] DUMMY_LAST = CW'(DUMMY_CLKS - 1);

  logic [CW-1:0]    cnt;
  logic [7:0]       op_sr;
  logic [7:0]       op_full;
  logic [OFS_W-1:0] ofs_sr;

  assign op_full       = push_pair(op_sr, dq_in);
  assign start_ofs     = ofs_sr;
  assign ev_data_start = !cs_n && (phase == PH_DUMMY) && (cnt == DUMMY_LAST);

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      wop    <= WOP_NONE;
      cnt    <= '0;
      op_sr  <= '0;
      ofs_sr <= '0;
    end else if (cs_n) begin
      phase <= PH_CMD;
      wop   <= WOP_NONE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_CMD: begin
          op_sr <= op_full;
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            case (op_full)
              OP_OTP_RD: phase <= PH_ADDR;
              OP_WR_EN:  begin phase <= PH_HOLD; wop <= WOP_SET; end
              OP_WR_DIS: begin phase <= PH_HOLD; wop <= WOP_CLR; end
              default:   phase <= PH_SKIP;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          ofs_sr <= {ofs_sr[OFS_W-3:0], dq_in};
          if (cnt == ADDR_LAST) begin
            cnt   <= '0;
            phase <= PH_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == DUMMY_LAST) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          phase <= PH_SKIP;
          wop   <= WOP_NONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dio_otp_store.sv
`timescale 1ns/1ps
module dio_otp_store #(
  parameter int BYTES = 64,
  parameter int OFS_W = 6
) (
  input  logic             sck,
  input  logic             cs_n,
  input  logic             pre_we,
  input  logic [OFS_W-1:0] pre_addr,
  input  logic [7:0]       pre_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge sck) begin
    if (pre_we && cs_n) mem[pre_addr] <= pre_data;
  end

  assign rd_data = mem[rd_ofs];
endmodule

// File: rtl/dio_data_tx.sv
`timescale 1ns/1ps
module dio_data_tx
  import dio_otp_pkg::*;
#(
  parameter int BYTES = 64,
  parameter int OFS_W = 6
) (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             cs_n,
  input  phase_t           phase,
  input  logic             ev_data_start,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic [7:0]       rd_data,
  output logic [OFS_W-1:0] rd_ofs,
  output logic [1:0]       dq_out,
  output logic             drive,
  output logic             ev_byte_adv
);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BYTES - 1);

  logic [1:0] pidx;

  assign ev_byte_adv = !cs_n && (phase == PH_DATA) && (pidx == 2'd3);

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      rd_ofs <= '0;
      pidx   <= '0;
    end else if (ev_data_start) begin
      rd_ofs <= start_ofs;
      pidx   <= '0;
    end else if (!cs_n && phase == PH_DATA) begin
      pidx <= pidx + 1'b1;
      if (ev_byte_adv) rd_ofs <= (rd_ofs == LAST_OFS) ? '0 : rd_ofs + 1'b1;
    end
  end

  // launch on the falling edge so the host samples a settled pair
  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      drive  <= 1'b0;
    end else if (!cs_n && phase == PH_DATA) begin
      dq_out <= byte_pair(rd_data, pidx);
      drive  <= 1'b1;
    end else begin
      drive  <= 1'b0;
    end
  end
endmodule

// File: rtl/dio_wel_latch.sv
`timescale 1ns/1ps
module dio_wel_latch
  import dio_otp_pkg::*;
(
  input  logic sck,
  input  logic rst_n,
  input  logic cs_n,
  input  wop_t wop,
  output logic wel
);
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (cs_n) begin
      if (wop == WOP_SET)      wel <= 1'b1;
      else if (wop == WOP_CLR) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/dio_otp_responder.sv
`timescale 1ns/1ps
module dio_otp_responder
  import dio_otp_pkg::*;
#(
  parameter int OTP_BYTES  = 64,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_CLKS = 8,
  localparam int OFS_W     = $clog2(OTP_BYTES)
) (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [1:0]       dq_in,
  output logic [1:0]       dq_out,
  output logic [1:0]       dq_oe,
  input  logic             pre_we,
  input  logic [OFS_W-1:0] pre_addr,
  input  logic [7:0]       pre_data,
  output logic             wel
);
  phase_t           phase;
  wop_t             wop;
  logic [OFS_W-1:0] start_ofs;
  logic [OFS_W-1:0] rd_ofs;
  logic [7:0]       rd_data;
  logic             ev_data_start;
  logic             ev_byte_adv;
  logic             drive;

  dio_frame_ctl #(.ADDR_BITS(ADDR_BITS), .DUMMY_CLKS(DUMMY_CLKS), .OFS_W(OFS_W)) u_ctl (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in),
    .phase(phase), .wop(wop), .start_ofs(start_ofs), .ev_data_start(ev_data_start)
  );

  dio_otp_store #(.BYTES(OTP_BYTES), .OFS_W(OFS_W)) u_mem (
    .sck(sck), .cs_n(cs_n), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .rd_ofs(rd_ofs), .rd_data(rd_data)
  );

  dio_data_tx #(.BYTES(OTP_BYTES), .OFS_W(OFS_W)) u_tx (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .phase(phase),
    .ev_data_start(ev_data_start), .start_ofs(start_ofs), .rd_data(rd_data),
    .rd_ofs(rd_ofs), .dq_out(dq_out), .drive(drive), .ev_byte_adv(ev_byte_adv)
  );

  dio_wel_latch u_wel (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .wop(wop), .wel(wel)
  );

  assign dq_oe = {2{drive & ~cs_n}};
endmodule

// File: rtl/dio_otp_chk.sv
`timescale 1ns/1ps
module dio_otp_chk
  import dio_otp_pkg::*;
#(
  parameter int BYTES = 64,
  parameter int OFS_W = 6
) (
  input logic             sck,
  input logic             rst_n,
  input logic             cs_n,
  input logic [1:0]       dq_oe,
  input logic             wel,
  input phase_t           phase,
  input wop_t             wop,
  input logic             ev_byte_adv,
  input logic [OFS_W-1:0] rd_ofs
);
  // R10
  release_chk: assert property (@(posedge sck) disable iff (!rst_n)
    $past(cs_n) |-> dq_oe == 2'b00);

  // R6
  wel_set_chk: assert property (@(posedge sck) disable iff (!rst_n)
    (cs_n && wop == WOP_SET) |=> wel);

  // R7
  wel_clr_chk: assert property (@(posedge sck) disable iff (!rst_n)
    (cs_n && wop == WOP_CLR) |=> !wel);

  // R8
  wel_hold_chk: assert property (@(posedge sck) disable iff (!rst_n)
    !cs_n |=> $stable(wel));

  // R3
  dummy_order_chk: assert property (@(posedge sck) disable iff (!rst_n)
    $rose(phase == PH_DATA) |-> $past(phase) == PH_DUMMY);

  // R5
  ofs_wrap_chk: assert property (@(posedge sck) disable iff (!rst_n)
    (ev_byte_adv && rd_ofs == OFS_W'(BYTES - 1)) |=> rd_ofs == '0);
endmodule

bind dio_otp_responder dio_otp_chk #(.BYTES(OTP_BYTES), .OFS_W(OFS_W)) u_chk (
  .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .dq_oe(dq_oe), .wel(wel),
  .phase(phase), .wop(wop), .ev_byte_adv(ev_byte_adv), .rd_ofs(rd_ofs)
);

// File: tb/sim_dio_otp_responder.sv
`timescale 1ns/1ps
module sim_dio_otp_responder;
  logic       sck = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] dq_in = 2'b00;
  logic [1:0] dq_out;
  logic [1:0] dq_oe;
  logic       pre_we = 1'b0;
  logic [5:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic       wel;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;
  logic [7:0] model [64];

  always #4 sck = ~sck;

  dio_otp_responder u0 (
    .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data), .wel(wel)
  );

  // read vectors: {byte count, 24-bit address}
  localparam logic [31:0] RD_VEC [6] = '{
    {8'd4,  24'h000000},
    {8'd3,  24'h00003E},
    {8'd2,  24'hABCD3F},
    {8'd5,  24'h000017},
    {8'd1,  24'hFFFFC7},
    {8'd66, 24'h00003D}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_in(input logic [1:0] p);
    @(negedge sck);
    cs_n  = 1'b0;
    dq_in = p;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) clk_in(2'((b >> (6 - 2 * k)) & 8'h3));
  endtask

  task automatic end_frame();
    @(negedge sck);
    cs_n  = 1'b1;
    dq_in = 2'b00;
    repeat (2) @(negedge sck);
  endtask

  task automatic read_byte(output logic [7:0] b, output logic oe_ok);
    b = '0;
    oe_ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge sck);
      cs_n = 1'b0;
      #2;
      if (dq_oe !== 2'b11) oe_ok = 1'b0;
      b = {b[5:0], dq_out};
    end
  endtask

  // opcode, address and dummy clocks; checks lines stay released
  task automatic read_head(input logic [23:0] a);
    logic quiet;
    quiet = 1'b1;
    send_byte(8'h4B);
    for (int k = 0; k < 12; k++) clk_in(2'((a >> (22 - 2 * k)) & 24'h3));
    for (int k = 0; k < 8; k++) begin
      clk_in(2'b00);
      #2;
      if (dq_oe !== 2'b00) quiet = 1'b0;
    end
    chk("R3 lines released through dummy", 32'(quiet), 32'd1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       ok;
    logic       quiet;
    int         ofs;
    repeat (3) @(negedge sck);
    #1;
    chk("R10 reset wel", 32'(wel), 32'd0);
    chk("R10 reset oe", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;

    // R11 preload
    for (int i = 0; i < 64; i++) begin
      @(negedge sck);
      pre_we   = 1'b1;
      pre_addr = 6'(i);
      pre_data = 8'((i * 37 + 5) & 255);
      model[i] = 8'((i * 37 + 5) & 255);
    end
    @(negedge sck);
    pre_we = 1'b0;

    // table of read vectors
    for (int v = 0; v < 6; v++) begin
      read_head(RD_VEC[v][23:0]);
      ofs = int'(RD_VEC[v][5:0]);
      for (int j = 0; j < int'(RD_VEC[v][31:24]); j++) begin
        read_byte(b, ok);
        chk(j == 0 ? "R1/R2/R4 first byte" : "R4/R5 stream byte", 32'(b), 32'(model[ofs]));
        if (j == 0) chk("R4 oe during data", 32'(ok), 32'd1);
        ofs = (ofs + 1) % 64;
      end
      end_frame();
    end

    // R11 overwrite one byte and read it back
    @(negedge sck);
    pre_we = 1'b1; pre_addr = 6'd7; pre_data = 8'hA5;
    model[7] = 8'hA5;
    @(negedge sck);
    pre_we = 1'b0;
    read_head(24'h000007);
    read_byte(b, ok);
    chk("R11 preload overwrite", 32'(b), 32'hA5);
    end_frame();

    // R6 set latch
    send_byte(8'h06);
    end_frame();
    chk("R6 wel set", 32'(wel), 32'd1);

    // R8 read frame keeps latch
    read_head(24'h000001);
    read_byte(b, ok);
    end_frame();
    chk("R8 read keeps wel", 32'(wel), 32'd1);

    // R8 aborted clear
    clk_in(2'b00); clk_in(2'b00); clk_in(2'b01);
    end_frame();
    chk("R8 aborted clear", 32'(wel), 32'd1);

    // R8 over-long clear
    send_byte(8'h04);
    clk_in(2'b00);
    end_frame();
    chk("R8 overlong clear", 32'(wel), 32'd1);

    // R7 clear
    send_byte(8'h04);
    end_frame();
    chk("R7 wel clear", 32'(wel), 32'd0);

    // R8 over-long set
    send_byte(8'h06);
    clk_in(2'b11); clk_in(2'b11);
    end_frame();
    chk("R8 overlong set", 32'(wel), 32'd0);

    // R9 unknown opcode, R1 pair-swapped read code
    send_byte(8'h9F);
    quiet = 1'b1;
    for (int k = 0; k < 30; k++) begin
      clk_in(2'(k));
      #2;
      if (dq_oe !== 2'b00) quiet = 1'b0;
    end
    end_frame();
    chk("R9 unknown opcode silent", 32'(quiet), 32'd1);
    chk("R9 unknown opcode wel", 32'(wel), 32'd0);
    send_byte(8'h87);
    quiet = 1'b1;
    for (int k = 0; k < 30; k++) begin
      clk_in(2'b00);
      #2;
      if (dq_oe !== 2'b00) quiet = 1'b0;
    end
    end_frame();
    chk("R1 swapped pairs not decoded", 32'(quiet), 32'd1);

    // R10 abort mid data, release, then restart
    read_head(24'h000000);
    read_byte(b, ok);
    @(negedge sck);
    cs_n = 1'b1;
    #1;
    chk("R10 release on cs high", 32'(dq_oe), 32'd0);
    repeat (2) @(negedge sck);
    send_byte(8'h06);
    end_frame();
    chk("R10 restart after abort", 32'(wel), 32'd1);

    // R10 abort during address, then full read
    send_byte(8'h4B);
    for (int k = 0; k < 5; k++) clk_in(2'b11);
    end_frame();
    read_head(24'h000020);
    read_byte(b, ok);
    chk("R10 read after address abort", 32'(b), 32'(model[32]));
    end_frame();

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule